// File: doc/BRIEF.md
# Halfword-Aligned Instruction Prefetch Buffer

This block sits between a single-ported instruction/data memory and the decoder of a processor whose instruction stream mixes 16-bit and 32-bit encodings. It reads whole 32-bit words into a small halfword queue. It takes the memory port only in cycles where the executing instruction leaves it free, and only while the queue has room for a full word. The decoder always sees the two oldest buffered halfwords and reports through a length-decode input whether the oldest one starts a long instruction. The block uses that input to decide whether it holds enough bytes to issue.

A taken branch drives a redirect with the target byte address. The queue is emptied and fetching restarts at the word that holds the target. When the target sits in the upper half of its word, the lower halfword of the first fetched word is dropped. Fetch timing depends only on the instruction sequence and on the memory-busy pattern, so stall behaviour can be predicted exactly.

Top module: `halfword_prefetch`

## Requirements
- R1: `fetch_waddr` is a word address. Each accepted fetch is followed by a request for the next word in sequence. The memory word at word address A carries halfword 2A in bits 15:0 and halfword 2A+1 in bits 31:16, and the lower halfword comes first in program order.
- R2: `fetch_req` is low in every cycle in which `mem_busy` or `redirect` is high.
- R3: The queue never holds more than 6 halfwords (3 words). When `mem_busy`, `redirect` and reset are low, `fetch_req` is high exactly when 4 or fewer halfwords are buffered.
- R4: While `out_valid` is high, `out_instr[15:0]` is the halfword at byte address `head_pc`.
- R5: `len32` high means the halfword on `out_instr[15:0]` starts a 32-bit instruction. `out_valid` is high exactly when the queue holds at least 2 halfwords in that case, and at least 1 otherwise.
- R6: `issue` with `out_valid` high consumes 1 or 2 halfwords, as `len32` selects, and `head_pc` advances by 2 or 4 in the next cycle. `issue` while `out_valid` is low, or in a redirect cycle, changes nothing.
- R7: A redirect empties the queue. In the next cycle `out_valid` is low and `head_pc` equals `redirect_pc`. Fetching resumes at word `redirect_pc[15:2]`, and when `redirect_pc[1]` is 1 only the upper halfword of that first word is kept.
- R8: After synchronous reset the queue is empty, `out_valid` and `fetch_req` are low, and `fetch_waddr` and `head_pc` are 0.
- R9: A 32-bit instruction that starts on the upper halfword of a word is issued whole. Its second halfword, from the following word, appears on `out_instr[31:16]`.
- R10: With `mem_busy` low and `issue` high in every cycle, `out_valid` stays high in every cycle after it first rises, for a 16-bit stream, a 32-bit stream and a mixed stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_busy | input | 1 | The executing instruction uses the memory port this cycle |
| redirect | input | 1 | Taken branch: flush and restart at `redirect_pc` |
| redirect_pc | input | 16 | Branch target byte address (halfword aligned) |
| fetch_req | output | 1 | Instruction word read this cycle |
| fetch_waddr | output | 14 | Word address of the read |
| mem_rdata | input | 32 | Word returned for `fetch_waddr` in the same cycle |
| len32 | input | 1 | Decoder length decode of `out_instr[15:0]` |
| issue | input | 1 | Decoder takes the presented instruction |
| out_valid | output | 1 | Enough halfwords buffered for the presented instruction |
| out_instr | output | 32 | Oldest two buffered halfwords, oldest in bits 15:0 |
| head_pc | output | 16 | Byte address of `out_instr[15:0]` |

## Verification
A wrong fill count shows within one cycle as a `fetch_req` that disagrees with the four-halfword room rule, or as an `out_valid` that disagrees with the length rule. A misplaced halfword in the queue shows as a wrong `out_instr` at the next issue. A bad skip or a bad address step after a redirect shows as the wrong halfword at `head_pc`, at the latest two cycles after the target word arrives. The bench sweeps every memory-busy and issue pattern against even and odd targets and short, long and mixed streams, and predicts each cycle from a halfword count model.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    typedef logic [15:0] half_t;
    typedef logic [1:0]  hcnt_t;

    // halfwords delivered by one fetched word
    typedef struct packed {
        hcnt_t n;
        half_t first;
        half_t second;
    } push_t;

    function automatic hcnt_t need_of(input logic is_long);
        return is_long ? 2'd2 : 2'd1;
    endfunction

    function automatic push_t split_word(input logic [31:0] w, input logic skip_lo);
        push_t p;
        p.n      = skip_lo ? 2'd1 : 2'd2;
        p.first  = skip_lo ? w[31:16] : w[15:0];
        p.second = w[31:16];
        return p;
    endfunction

endpackage

// File: rtl/hpf_fetch_ctrl.sv
module hpf_fetch_ctrl
    import hpf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NHW   = 6,
    parameter int CNT_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mem_busy,
    input  logic            redirect,
    input  logic [AW-1:1]   redirect_hw,
    input  logic [CNT_W-1:0] fill,
    input  logic [31:0]     mem_rdata,
    output logic            fetch_req,
    output logic [AW-3:0]   fetch_waddr,
    output push_t           push
);
    localparam logic [CNT_W-1:0] ROOM_LVL = CNT_W'(NHW - 2);

    logic skip_lo;

    assign fetch_req = !rst && !redirect && !mem_busy && (fill <= ROOM_LVL);

    always_comb begin
        push = '0;
        if (fetch_req) push = split_word(mem_rdata, skip_lo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_waddr <= '0;
            skip_lo     <= 1'b0;
        end else if (redirect) begin
            fetch_waddr <= redirect_hw[AW-1:2];
            skip_lo     <= redirect_hw[1];
        end else if (fetch_req) begin
            fetch_waddr <= fetch_waddr + 1'b1;
            skip_lo     <= 1'b0;
        end
    end

    AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> fetch_waddr == $past(fetch_waddr) + 1'b1); // R1
    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
        redirect |=> fetch_waddr == $past(redirect_hw[AW-1:2])); // R7

endmodule

// File: rtl/hpf_hw_queue.sv
module hpf_hw_queue
    import hpf_pkg::*;
#(
    parameter int NHW   = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  hcnt_t            pop,
    input  push_t            push,
    output logic [CNT_W-1:0] fill,
    output logic [31:0]      head
);
    localparam int IDX_W = $clog2(NHW);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(NHW);

    half_t q     [NHW];
    half_t q_nxt [NHW];
    logic [CNT_W-1:0] fill_nxt;

    for (genvar g = 0; g < NHW; g++) begin : g_slot
        int src;
        int rel;
        always_comb begin
            src = g + int'(pop);
            rel = src - int'(fill);
            if (flush)
                q_nxt[g] = '0;
            else if (rel < 0)
                q_nxt[g] = q[src[IDX_W-1:0]];
            else if (rel == 0 && push.n != 2'd0)
                q_nxt[g] = push.first;
            else if (rel == 1 && push.n == 2'd2)
                q_nxt[g] = push.second;
            else
                q_nxt[g] = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) q[g] <= '0;
            else     q[g] <= q_nxt[g];
        end
    end

    always_comb begin
        if (flush) fill_nxt = '0;
        else       fill_nxt = CNT_W'(int'(fill) - int'(pop) + int'(push.n));
    end

    always_ff @(posedge clk) begin
        if (rst) fill <= '0;
        else     fill <= fill_nxt;
    end

    assign head = {q[1], q[0]};

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        fill <= CAP); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(pop) <= int'(fill)); // R6

endmodule

// File: rtl/hpf_issue.sv
module hpf_issue
    import hpf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             redirect,
    input  logic [AW-1:0]    redirect_pc,
    input  logic             len32,
    input  logic             issue,
    input  logic [CNT_W-1:0] fill,
    output logic             out_valid,
    output hcnt_t            pop,
    output logic [AW-1:0]    head_pc
);
    hcnt_t need;

    assign need      = need_of(len32);
    assign out_valid = fill >= CNT_W'(need);
    assign pop       = (issue && out_valid && !redirect) ? need : 2'd0;

    always_ff @(posedge clk) begin
        if (rst)
            head_pc <= '0;
        else if (redirect)
            head_pc <= redirect_pc;
        else if (pop != 2'd0)
            head_pc <= head_pc + AW'({pop, 1'b0});
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (issue && out_valid && !redirect) |=>
            head_pc == $past(head_pc) + ($past(len32) ? AW'(4) : AW'(2))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!redirect && !(issue && out_valid)) |=> $stable(head_pc)); // R6

endmodule

// File: rtl/halfword_prefetch.sv
module halfword_prefetch
    import hpf_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NWORDS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mem_busy,
    input  logic          redirect,
    input  logic [AW-1:0] redirect_pc,
    output logic          fetch_req,
    output logic [AW-3:0] fetch_waddr,
    input  logic [31:0]   mem_rdata,
    input  logic          len32,
    input  logic          issue,
    output logic          out_valid,
    output logic [31:0]   out_instr,
    output logic [AW-1:0] head_pc
);
    localparam int NHW   = 2 * NWORDS;
    localparam int CNT_W = $clog2(NHW + 1);

    logic [CNT_W-1:0] fill;
    push_t            push;
    hcnt_t            pop;

    hpf_fetch_ctrl #(.AW(AW), .NHW(NHW), .CNT_W(CNT_W)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .mem_busy    (mem_busy),
        .redirect    (redirect),
        .redirect_hw (redirect_pc[AW-1:1]),
        .fill        (fill),
        .mem_rdata   (mem_rdata),
        .fetch_req   (fetch_req),
        .fetch_waddr (fetch_waddr),
        .push        (push)
    );

    hpf_hw_queue #(.NHW(NHW), .CNT_W(CNT_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .flush (redirect),
        .pop   (pop),
        .push  (push),
        .fill  (fill),
        .head  (out_instr)
    );

    hpf_issue #(.AW(AW), .CNT_W(CNT_W)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .len32       (len32),
        .issue       (issue),
        .fill        (fill),
        .out_valid   (out_valid),
        .pop         (pop),
        .head_pc     (head_pc)
    );

    AST_BUSY_YIELD: assert property (@(posedge clk) disable iff (rst)
        (mem_busy || redirect) |-> !fetch_req); // R2
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !out_valid); // R7

endmodule

// File: tb/sim_halfword_prefetch.sv
`timescale 1ns/1ps
module sim_halfword_prefetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_busy = 1'b0;
    logic        redirect = 1'b0;
    logic [15:0] redirect_pc = '0;
    logic        fetch_req;
    logic [13:0] fetch_waddr;
    logic [31:0] mem_rdata;
    logic        len32;
    logic        issue = 1'b0;
    logic        out_valid;
    logic [31:0] out_instr;
    logic [15:0] head_pc;

    int n_chk = 0;
    int n_bad = 0;
    int pat   = 0;

    int m_cnt, m_addr, m_pc;
    bit m_skip;

    always #2 clk = ~clk;

    halfword_prefetch u0 (
        .clk(clk), .rst(rst), .mem_busy(mem_busy), .redirect(redirect),
        .redirect_pc(redirect_pc), .fetch_req(fetch_req), .fetch_waddr(fetch_waddr),
        .mem_rdata(mem_rdata), .len32(len32), .issue(issue), .out_valid(out_valid),
        .out_instr(out_instr), .head_pc(head_pc)
    );

    // halfword h of the program; top five bits all ones marks a long instruction
    function automatic logic [15:0] hw_val(input int h, input int p);
        logic lng;
        lng = (p == 0) ? 1'b0 : (p == 1) ? 1'b1 : ((h * 5) % 3 == 0);
        return {lng ? 5'h1f : 5'h00, 11'(h * 37 + p * 101)};
    endfunction

    assign mem_rdata = {hw_val(2 * int'(fetch_waddr) + 1, pat), hw_val(2 * int'(fetch_waddr), pat)};
    assign len32     = (out_instr[15:11] == 5'h1f);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit busy_pat(input int sel, input int c);
        case (sel)
            0: return 1'b0;
            1: return (c % 3) == 1;
            2: return (c % 2) == 0;
            default: return ((c / 4) % 2) == 1;
        endcase
    endfunction

    function automatic bit iss_pat(input int sel, input int c);
        case (sel)
            0: return 1'b1;
            1: return (c % 2) == 1;
            2: return (c % 5) != 0;
            default: return (c % 7) < 2;
        endcase
    endfunction

    // one cycle per iteration, entered and left at a falling edge
    task automatic run_loop(input int bsel, input int isel, input int ncyc);
        bit seen = 0;
        for (int c = 0; c < ncyc; c++) begin
            int need, consumed, pushed;
            bit expv, b, iv, expf;
            need = len32 ? 2 : 1;
            expv = (m_cnt >= need);
            chk(out_valid == expv, "R5 out_valid", 32'(out_valid), 32'(expv));
            if (expv) begin
                chk(head_pc == 16'(m_pc), "R6 head_pc", 32'(head_pc), 32'(m_pc));
                chk(out_instr[15:0] == hw_val(m_pc / 2, pat), "R4 head halfword",
                    32'(out_instr[15:0]), 32'(hw_val(m_pc / 2, pat)));
                if (need == 2)
                    chk(out_instr[31:16] == hw_val(m_pc / 2 + 1, pat), "R9 second halfword",
                        32'(out_instr[31:16]), 32'(hw_val(m_pc / 2 + 1, pat)));
            end
            if (bsel == 0 && isel == 0 && seen)
                chk(out_valid == 1'b1, "R10 sustained issue", 32'(out_valid), 32'd1);
            if (expv) seen = 1;
            b  = busy_pat(bsel, c);
            iv = iss_pat(isel, c);
            mem_busy = b;
            issue    = iv;
            #1;
            expf = !b && (m_cnt <= 4);
            chk(fetch_req == expf, b ? "R2 busy blocks fetch" : "R3 room rule",
                32'(fetch_req), 32'(expf));
            if (fetch_req && expf)
                chk(int'(fetch_waddr) == m_addr, "R1 fetch address", 32'(fetch_waddr), 32'(m_addr));
            consumed = (iv && expv) ? need : 0;
            pushed   = expf ? (m_skip ? 1 : 2) : 0;
            if (expf) begin
                m_addr++;
                m_skip = 0;
            end
            m_cnt = m_cnt + pushed - consumed;
            m_pc  = (m_pc + 2 * consumed) & 16'hffff;
            @(negedge clk);
        end
    endtask

    task automatic do_redirect(input int target);
        redirect    = 1'b1;
        redirect_pc = 16'(target);
        issue       = 1'b1;
        mem_busy    = 1'b0;
        #1;
        chk(fetch_req == 1'b0, "R2 redirect blocks fetch", 32'(fetch_req), 32'd0);
        @(negedge clk);
        redirect = 1'b0;
        issue    = 1'b0;
        m_cnt  = 0;
        m_addr = target >> 2;
        m_skip = target[1];
        m_pc   = target;
        chk(out_valid == 1'b0, "R7 flushed", 32'(out_valid), 32'd0);
        chk(head_pc == 16'(target), "R7 head_pc", 32'(head_pc), 32'(target));
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int targets[4] = '{16'h0040, 16'h0042, 16'h0100, 16'h010a};
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8 out_valid", 32'(out_valid), 32'd0);
        chk(fetch_req == 1'b0, "R8 fetch_req", 32'(fetch_req), 32'd0);
        chk(fetch_waddr == '0, "R8 fetch_waddr", 32'(fetch_waddr), 32'd0);
        chk(head_pc == '0, "R8 head_pc", 32'(head_pc), 32'd0);
        rst = 1'b0;
        m_cnt = 0; m_addr = 0; m_pc = 0; m_skip = 0;
        pat = 0;
        run_loop(0, 0, 30);
        for (int p = 0; p < 3; p++) begin
            pat = p;
            for (int t = 0; t < 4; t++)
                for (int bs = 0; bs < 4; bs++)
                    for (int is = 0; is < 4; is++) begin
                        do_redirect(targets[t] + 64 * bs);
                        run_loop(bs, is, 40);
                    end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule